// File: doc/BRIEF.md
# Serial NAND Page Read Sequencer

This block is a single-lane SPI master that fetches bytes from one page of a serial NAND flash. The flash organises its array as blocks of 64 pages of 2048 bytes each. A page cannot be read straight from the array: it first has to be copied into an on-die cache of the same size. The host gives a block number, a page number, a starting column, a two-bit wrap selection and a byte count. A single start pulse then runs the whole read.

The sequencer runs three kinds of command in order. First it sends a row-addressed load that copies the page into the cache. Next it polls the status feature until the busy bit clears, giving up after a set number of polls. Last it sends a column-addressed cache read and passes the returned bytes to the host on a valid/ready byte stream. Back-pressure is applied at the byte level. When a received byte is waiting on `out_valid` without `out_ready`, SCK stops low. The next byte is not clocked in until the host accepts the current one. Each byte therefore stays on `out_data` unchanged until it is taken, and no byte is ever dropped.

Top module: `spinand_page_reader`

## Requirements
- R1: `start` is acted on only while `busy` is low. `busy` rises on the clock after an accepted start and stays high until the block is idle again. A start pulse seen while `busy` is high changes no command that is sent.
- R2: The load command is one CS_n-low frame of four bytes: opcode 0x13, then a 24-bit row value sent MSB first. The row value is zero above bit 16, the block number is in bits 16:6 and the page number is in bits 5:0.
- R3: Each status poll is a frame of three bytes: opcode 0x0F, feature address 0xC0, then one byte read back. Bit 0 of the byte read back equal to 1 means busy, and busy causes another poll frame.
- R4: If POLL_MAX polls in a row all report busy, `done` and `timeout` pulse together on the clock after the last poll frame ends. No cache read is sent.
- R5: The cache read is one frame: opcode 0x03, then a 16-bit column word sent MSB first, then 8 dummy clocks, then `byte_len` data bytes. The column word holds the wrap selection in bits 15:14, zero in bits 13:12 and the start column in bits 11:0.
- R6: The bus uses SPI mode 0. SCK is low whenever CS_n is high. MOSI changes only while SCK is low. MISO is sampled on the rising edge, MSB first. Every SCK high phase lasts HALF_DIV system clocks.
- R7: Between two consecutive frames, CS_n stays high for at least CS_GAP system clocks.
- R8: A byte on `out_valid` holds `out_data` stable until `out_ready` is seen. SCK stays low while a byte is waiting. The bytes arrive in cache order, one for each cache address starting at the start column.
- R9: When the read completes, `done` is a single-cycle pulse with `timeout` low. It comes on the clock after the last byte is accepted.
- R10: A `byte_len` of zero still sends the load, the polls and the cache-read header. `done` then pulses with no data byte delivered.
- R11: Coming out of reset, CS_n is high, SCK is low, MOSI is low, and `busy`, `done`, `timeout` and `out_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a page read (taken only when idle) |
| blk_num | input | BLK_W | Block number |
| pg_num | input | PG_W | Page number within the block |
| col_start | input | COL_W | First byte column in the cache |
| wrap_sel | input | 2 | Wrap selection placed in the column word |
| byte_len | input | LEN_W | Number of bytes to deliver |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Pulses together with done when polling gave up |
| out_valid | output | 1 | Received byte available |
| out_ready | input | 1 | Host accepts the byte |
| out_data | output | 8 | Received byte |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Some properties can be checked every cycle. The assertions hold the following at all times: SCK is low with chip select high, MOSI moves only with SCK low, and the minimum chip-select high time. They also check that a waiting byte holds steady while SCK is paused, and that done and timeout are single pulses tied to each other. Other behaviour only shows up across a whole transaction, and the bench scenarios cover it. A behavioural flash model decodes each frame. The scenarios check the row and column packing, the number of busy polls, the timeout path, column wrap across the end of the cache, zero-length reads and a start that arrives mid-transaction. A reference queue checks the byte order under random back-pressure.

// File: rtl/spinand_rd_pkg.sv
package spinand_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_GAP,
    ST_POLL,
    ST_HDR,
    ST_DATA,
    ST_HOLD
  } seq_st_e;

  localparam logic [7:0] OP_PAGE_LOAD = 8'h13;
  localparam logic [7:0] OP_FEAT_RD   = 8'h0F;
  localparam logic [7:0] OP_CACHE_RD  = 8'h03;
  localparam logic [7:0] FEAT_STATUS  = 8'hC0;
endpackage

// File: rtl/spinand_bit_engine.sv
// Shifts one byte in mode 0: MOSI is set up while SCK is low,
// MISO is captured as SCK rises, and SCK ends low after 8 bits.
module spinand_bit_engine #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       fin,
  output logic [7:0] rx
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          active;
  logic          hi_phase;
  logic [DW-1:0] dcnt;
  logic [2:0]    bcnt;
  logic [7:0]    sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      hi_phase <= 1'b0;
      dcnt     <= '0;
      bcnt     <= '0;
      sh       <= '0;
      sck      <= 1'b0;
      mosi     <= 1'b0;
      fin      <= 1'b0;
      rx       <= '0;
    end else begin
      fin <= 1'b0;
      if (go && !active) begin
        active   <= 1'b1;
        sh       <= tx;
        mosi     <= tx[7];
        dcnt     <= '0;
        bcnt     <= '0;
        hi_phase <= 1'b0;
        sck      <= 1'b0;
      end else if (active) begin
        if (dcnt == DW'(HALF_DIV - 1)) begin
          dcnt <= '0;
          if (!hi_phase) begin
            sck      <= 1'b1;
            hi_phase <= 1'b1;
            rx       <= {rx[6:0], miso};
          end else begin
            sck      <= 1'b0;
            hi_phase <= 1'b0;
            if (bcnt == 3'd7) begin
              active <= 1'b0;
              fin    <= 1'b1;
            end else begin
              bcnt <= bcnt + 3'd1;
              sh   <= {sh[6:0], 1'b0};
              mosi <= sh[6];
            end
          end
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spinand_rd_seq.sv
// Command sequencer: page load, status polling, cache readout.
module spinand_rd_seq
  import spinand_rd_pkg::*;
#(
  parameter int CS_GAP   = 4,
  parameter int POLL_MAX = 16,
  parameter int BLK_W    = 11,
  parameter int PG_W     = 6,
  parameter int COL_W    = 12,
  parameter int LEN_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] blk_num,
  input  logic [PG_W-1:0]  pg_num,
  input  logic [COL_W-1:0] col_start,
  input  logic [1:0]       wrap_sel,
  input  logic [LEN_W-1:0] byte_len,
  input  logic             out_ready,
  input  logic             fin,
  input  logic [7:0]       rx,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             cs_n,
  output logic             go,
  output logic [7:0]       tx
);
  localparam int GW = $clog2(CS_GAP + 1);
  localparam int PW = $clog2(POLL_MAX + 1);

  seq_st_e          st, nxt;
  logic [1:0]       idx;
  logic [GW-1:0]    gap_cnt;
  logic [PW-1:0]    poll_cnt;
  logic [LEN_W-1:0] remain;
  logic [BLK_W-1:0] blk_q;
  logic [PG_W-1:0]  pg_q;
  logic [COL_W-1:0] col_q;
  logic [1:0]       wrap_q;
  logic [23:0]      row24;
  logic [15:0]      colw;
  logic [7:0]       row_byte;
  logic [7:0]       hdr_byte;

  assign row24 = 24'({blk_q, pg_q});
  assign colw  = {wrap_q, 14'(col_q)};
  assign busy  = (st != ST_IDLE);

  always_comb begin
    case (idx)
      2'd0:    row_byte = row24[23:16];
      2'd1:    row_byte = row24[15:8];
      default: row_byte = row24[7:0];
    endcase
    case (idx)
      2'd0:    hdr_byte = colw[15:8];
      2'd1:    hdr_byte = colw[7:0];
      default: hdr_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      nxt       <= ST_IDLE;
      idx       <= '0;
      gap_cnt   <= '0;
      poll_cnt  <= '0;
      remain    <= '0;
      blk_q     <= '0;
      pg_q      <= '0;
      col_q     <= '0;
      wrap_q    <= '0;
      done      <= 1'b0;
      timeout   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      cs_n      <= 1'b1;
      go        <= 1'b0;
      tx        <= '0;
    end else begin
      go      <= 1'b0;
      done    <= 1'b0;
      timeout <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            blk_q    <= blk_num;
            pg_q     <= pg_num;
            col_q    <= col_start;
            wrap_q   <= wrap_sel;
            remain   <= byte_len;
            poll_cnt <= '0;
            idx      <= '0;
            cs_n     <= 1'b0;
            go       <= 1'b1;
            tx       <= OP_PAGE_LOAD;
            st       <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (fin) begin
            if (idx == 2'd3) begin
              cs_n    <= 1'b1;
              gap_cnt <= '0;
              nxt     <= ST_POLL;
              st      <= ST_GAP;
            end else begin
              go  <= 1'b1;
              tx  <= row_byte;
              idx <= idx + 2'd1;
            end
          end
        end
        ST_GAP: begin
          if (gap_cnt == GW'(CS_GAP - 1)) begin
            idx <= '0;
            st  <= nxt;
            if (nxt != ST_IDLE) begin
              cs_n <= 1'b0;
              go   <= 1'b1;
              tx   <= (nxt == ST_POLL) ? OP_FEAT_RD : OP_CACHE_RD;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_POLL: begin
          if (fin) begin
            if (idx != 2'd2) begin
              go  <= 1'b1;
              tx  <= (idx == 2'd0) ? FEAT_STATUS : 8'h00;
              idx <= idx + 2'd1;
            end else begin
              cs_n    <= 1'b1;
              gap_cnt <= '0;
              st      <= ST_GAP;
              if (!rx[0]) begin
                nxt <= ST_HDR;
              end else if (poll_cnt == PW'(POLL_MAX - 1)) begin
                nxt     <= ST_IDLE;
                done    <= 1'b1;
                timeout <= 1'b1;
              end else begin
                poll_cnt <= poll_cnt + 1'b1;
                nxt      <= ST_POLL;
              end
            end
          end
        end
        ST_HDR: begin
          if (fin) begin
            if (idx != 2'd3) begin
              go  <= 1'b1;
              tx  <= hdr_byte;
              idx <= idx + 2'd1;
            end else if (remain == '0) begin
              cs_n    <= 1'b1;
              done    <= 1'b1;
              gap_cnt <= '0;
              nxt     <= ST_IDLE;
              st      <= ST_GAP;
            end else begin
              go <= 1'b1;
              tx <= 8'h00;
              st <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (fin) begin
            out_valid <= 1'b1;
            out_data  <= rx;
            remain    <= remain - 1'b1;
            st        <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            if (remain == '0) begin
              cs_n    <= 1'b1;
              done    <= 1'b1;
              gap_cnt <= '0;
              nxt     <= ST_IDLE;
              st      <= ST_GAP;
            end else begin
              go <= 1'b1;
              tx <= 8'h00;
              st <= ST_DATA;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spinand_page_reader.sv
module spinand_page_reader #(
  parameter int HALF_DIV = 2,
  parameter int CS_GAP   = 4,
  parameter int POLL_MAX = 16,
  parameter int BLK_W    = 11,
  parameter int PG_W     = 6,
  parameter int COL_W    = 12,
  parameter int LEN_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BLK_W-1:0] blk_num,
  input  logic [PG_W-1:0]  pg_num,
  input  logic [COL_W-1:0] col_start,
  input  logic [1:0]       wrap_sel,
  input  logic [LEN_W-1:0] byte_len,
  output logic             busy,
  output logic             done,
  output logic             timeout,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);
  logic       eng_go;
  logic [7:0] eng_tx;
  logic       eng_fin;
  logic [7:0] eng_rx;

  spinand_rd_seq #(
    .CS_GAP(CS_GAP), .POLL_MAX(POLL_MAX), .BLK_W(BLK_W),
    .PG_W(PG_W), .COL_W(COL_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_num(blk_num),
    .pg_num(pg_num), .col_start(col_start), .wrap_sel(wrap_sel),
    .byte_len(byte_len), .out_ready(out_ready), .fin(eng_fin),
    .rx(eng_rx), .busy(busy), .done(done), .timeout(timeout),
    .out_valid(out_valid), .out_data(out_data), .cs_n(cs_n),
    .go(eng_go), .tx(eng_tx)
  );

  spinand_bit_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .tx(eng_tx), .miso(miso),
    .sck(sck), .mosi(mosi), .fin(eng_fin), .rx(eng_rx)
  );
endmodule

// File: rtl/spinand_rd_chk.sv
module spinand_rd_chk #(
  parameter int CS_GAP = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       timeout,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       sck,
  input logic       cs_n,
  input logic       mosi
);
  localparam int HW = $clog2(CS_GAP + 1) + 1;
  logic [HW-1:0] hi_cnt;

  // cycles that chip select has been high, saturating at CS_GAP
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= HW'(CS_GAP);
    else if (!cs_n) hi_cnt <= '0;
    else if (hi_cnt < HW'(CS_GAP)) hi_cnt <= hi_cnt + 1'b1;
  end

  p_cs_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_timeout_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (done && !out_valid));
  p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_mosi_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sck);
  p_cs_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= HW'(CS_GAP)));
  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_sck_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !sck);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind spinand_page_reader spinand_rd_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .timeout(timeout), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .sck(sck), .cs_n(cs_n), .mosi(mosi)
);

// File: tb/spinand_page_reader_tb.sv
`timescale 1ns/1ps
module spinand_page_reader_tb;
  localparam int HALF_DIV = 2;
  localparam int CS_GAP   = 4;
  localparam int POLL_MAX = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [10:0] blk_num = '0;
  logic [5:0]  pg_num = '0;
  logic [11:0] col_start = '0;
  logic [1:0]  wrap_sel = '0;
  logic [11:0] byte_len = '0;
  logic out_ready = 1'b1;
  logic miso = 1'b0;
  logic busy, done, timeout, out_valid, sck, cs_n, mosi;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  spinand_page_reader u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_num(blk_num),
    .pg_num(pg_num), .col_start(col_start), .wrap_sel(wrap_sel),
    .byte_len(byte_len), .busy(busy), .done(done), .timeout(timeout),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [7:0] pat(input int row, input int col);
    return 8'((row * 5) + (col * 3) + (col >> 8));
  endfunction

  // ---------------- behavioural flash model ----------------
  logic [7:0] fr[$];
  logic [7:0] cur = '0;
  int bitk = 0;
  int busy_cfg = 0;
  int busy_left = 0;
  int row_q = 0;
  int f_op[$], f_b1[$], f_b2[$], f_b3[$], f_len[$];

  function automatic logic resp_bit(input int k);
    int idx, col;
    logic [7:0] b;
    if (fr.size() == 0) return 1'b0;
    if (fr[0] == 8'h0F && k >= 16 && k < 24) begin
      b = {7'b0, (busy_left > 0)};
      return b[7 - (k - 16)];
    end
    if (fr[0] == 8'h03 && k >= 32) begin
      idx = (k - 32) / 8;
      col = (int'({fr[1][3:0], fr[2]}) + idx) % 2048;
      b = pat(row_q, col);
      return b[7 - ((k - 32) % 8)];
    end
    return 1'b0;
  endfunction

  always @(negedge cs_n) begin
    bitk = 0;
    fr.delete();
    miso = 1'b0;
  end

  always @(posedge sck) if (!cs_n) begin
    cur = {cur[6:0], mosi};
    bitk++;
    if (bitk % 8 == 0) fr.push_back(cur);
  end

  always @(negedge sck) if (!cs_n) miso = resp_bit(bitk);

  always @(posedge cs_n) if (rst_n) begin
    f_op.push_back(fr.size() > 0 ? int'(fr[0]) : -1);
    f_b1.push_back(fr.size() > 1 ? int'(fr[1]) : -1);
    f_b2.push_back(fr.size() > 2 ? int'(fr[2]) : -1);
    f_b3.push_back(fr.size() > 3 ? int'(fr[3]) : -1);
    f_len.push_back(fr.size());
    if (fr.size() == 4 && fr[0] == 8'h13) begin
      row_q = int'({fr[1], fr[2], fr[3]});
      busy_left = busy_cfg;
    end
    if (fr.size() > 0 && fr[0] == 8'h0F && busy_left > 0) busy_left--;
  end

  // ---------------- per-clock reference comparison ----------------
  logic [7:0] exp_q[$];
  bit rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;
  int cyc = 0;
  int last_hs = -10;
  int hi_w = 0;
  int cur_len = 0;
  bit done_seen = 0;
  bit to_seen = 0;
  logic [7:0] held;
  bit held_v = 0;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = rdy_rand ? lfsr[0] : 1'b1;
  end

  always @(posedge clk) if (rst_n) begin
    // R6: every SCK high phase lasts HALF_DIV clocks
    if (sck) hi_w++;
    else if (hi_w != 0) begin
      chk(hi_w == HALF_DIV, "R6 sck high width", hi_w, HALF_DIV);
      hi_w = 0;
    end
    // R8: waiting byte holds value
    if (held_v && out_valid)
      chk(out_data == held, "R8 data stable while waiting", out_data, held);
    held_v = out_valid && !out_ready;
    held = out_data;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected byte", out_data, -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R8 byte order/value", out_data, e);
      end
      last_hs = cyc;
    end
    if (done) begin
      done_seen = 1;
      to_seen = timeout;
      if (!timeout && cur_len > 0)
        chk(cyc == last_hs + 1, "R9 done one clock after last accept", cyc - last_hs, 1);
    end
    cyc++;
  end

  // ---------------- transaction task ----------------
  task automatic run_read(input int blk, input int pg, input int col, input int wr,
                          input int len, input int bsy, input bit rnd, input bit extra);
    int polls, n0, w, row, k;
    bit exp_to;
    exp_to = (bsy >= POLL_MAX);
    polls = exp_to ? POLL_MAX : bsy + 1;
    row = (blk << 6) | pg;
    busy_cfg = bsy;
    rdy_rand = rnd;
    cur_len = exp_to ? 0 : len;
    if (!exp_to) for (int i = 0; i < len; i++) exp_q.push_back(pat(row, (col + i) % 2048));
    n0 = f_op.size();
    done_seen = 0;
    @(negedge clk);
    blk_num = 11'(blk); pg_num = 6'(pg); col_start = 12'(col);
    wrap_sel = 2'(wr); byte_len = 12'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    if (extra) begin
      repeat (40) @(negedge clk);
      blk_num = 11'(blk ^ 1); pg_num = 6'(pg ^ 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!done_seen && w < 60000) begin @(negedge clk); w++; end
    chk(done_seen, "R9 done reached", done_seen, 1);
    chk(to_seen == exp_to, "R4 timeout flag", to_seen, exp_to);
    w = 0;
    while (busy && w < 100) begin @(negedge clk); w++; end
    chk(!busy, "R1 busy drops after done", busy, 0);
    chk(f_op.size() - n0 == 1 + polls + (exp_to ? 0 : 1), "R3 frame count",
        f_op.size() - n0, 1 + polls + (exp_to ? 0 : 1));
    k = n0;
    // R2: load frame
    chk(f_op[k] == 8'h13 && f_len[k] == 4, "R2 load opcode/length", f_op[k], 8'h13);
    chk(f_b1[k] == ((row >> 16) & 255) && f_b2[k] == ((row >> 8) & 255) && f_b3[k] == (row & 255),
        "R2 row bytes", (f_b1[k] << 16) | (f_b2[k] << 8) | f_b3[k], row);
    k++;
    for (int p = 0; p < polls; p++) begin
      chk(f_op[k] == 8'h0F && f_b1[k] == 8'hC0 && f_len[k] == 3, "R3 poll frame", f_op[k], 8'h0F);
      k++;
    end
    if (!exp_to) begin
      chk(f_op[k] == 8'h03 && f_len[k] == 4 + len, "R5 cache read opcode/length", f_len[k], 4 + len);
      chk(((f_b1[k] << 8) | f_b2[k]) == ((wr << 14) | col), "R5 column word",
          (f_b1[k] << 8) | f_b2[k], (wr << 14) | col);
      chk(f_b3[k] == 0, "R5 dummy byte", f_b3[k], 0);
    end
    chk(exp_q.size() == 0, "R8 all bytes delivered", exp_q.size(), 0);
    exp_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cs_n == 1 && sck == 0 && mosi == 0, "R11 bus idle in reset", {cs_n, sck, mosi}, 3'b100);
    chk(!busy && !done && !timeout && !out_valid, "R11 status low in reset",
        {busy, done, timeout, out_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n == 1 && !busy, "R11 idle after reset", {cs_n, busy}, 2'b10);
    run_read(5, 3, 0, 0, 8, 2, 0, 0);            // R2 R3 R5 basic
    run_read(2047, 63, 2046, 2, 5, 0, 1, 0);     // R5 wrap bits, cache wrap, R8 back-pressure
    run_read(100, 17, 37, 1, 0, 1, 0, 0);        // R10 zero length
    run_read(9, 9, 500, 3, 4, 20, 0, 0);         // R4 timeout
    run_read(300, 40, 1000, 0, 12, 3, 1, 1);     // R1 extra start ignored
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    report();
  end
endmodule